// File: doc/BRIEF.md
# Microprocessor Reset Supervisor with Watchdog

This block merges three reasons to hold a processor in reset into one stretched reset. The first is a power-fail flag from an external supply comparator, synchronous to the clock. The second is an active-low pushbutton, which is debounced. The third is a watchdog that the processor keeps quiet by pulling a strobe line low. As long as any reason is present, the reset outputs stay active. After the last reason goes away they stay active for a fixed minimum time, which gives the supply and the processor time to settle.

All timing comes from one prescaled enable that pulses once per millisecond, derived from the system clock. The minimum reset time, the debounce time and the three watchdog periods are parameters counted in those milliseconds, so a simulation can use short values. The watchdog runs only while reset is inactive and has no way to be turned off. A two-bit select chooses its period.

The pushbutton and strobe inputs each pass through a two-flop synchronizer. An asynchronous active-low power-on input clears the whole block and starts a full reset interval.

Top module: `rst_supervisor`

## Requirements
- R1: The reset outputs go active at the first rising clock edge that samples `pwr_fail_i` high. They stay active for as long as `pwr_fail_i` is high.
- R2: After the last reset cause clears, reset is held for STRETCH_MS+1 millisecond ticks and then released. Because the first tick can arrive early, this is never less than STRETCH_MS milliseconds.
- R3: A low level on `pb_n_i` is accepted as a press only after the synchronized input has stayed low through DEBOUNCE_MS+1 ticks. A shorter low pulse has no effect on the reset outputs. Any high sample cancels the press at once.
- R4: For a pushbutton reset, the hold interval starts when the accepted press ends, that is, when `pb_n_i` returns high.
- R5: `wd_sel_i` sets the watchdog period. Code 2'b00 gives WD_SHORT_MS, 2'b01 gives WD_MID_MS, and 2'b10 or 2'b11 gives WD_LONG_MS. The watchdog fires once its count, which advances one per tick, has reached the selected period.
- R6: The watchdog count is held at zero while reset is active. Counting begins only after release, and a watchdog expiry can only occur while reset is inactive.
- R7: Only a high-to-low transition of the synchronized `strobe_i` restarts the watchdog from zero. A rising edge or a steady level does not restart it.
- R8: When the watchdog expires, reset is asserted and stretched as in R2. Without strobe falling edges, these reset pulses repeat without end. No input disables this.
- R9: `rst_n_o` is always the exact complement of `rst_o`.
- R10: While `por_n_i` is low, `rst_o` is 1 and every counter is cleared. After `por_n_i` rises, a full hold interval as in R2 follows.
- R11: A cause that becomes active during a hold interval restarts the interval. The interval is then counted from the release of that cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| pwr_fail_i | input | 1 | Supply-fail flag from the external comparator, synchronous to `clk`, active high |
| pb_n_i | input | 1 | Pushbutton, active low, asynchronous |
| strobe_i | input | 1 | Watchdog strobe; a falling edge restarts the watchdog |
| wd_sel_i | input | 2 | Watchdog period select (00 short, 01 mid, 10/11 long) |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
The bench targets the release instant of every stretch. An off-by-one tick there would release reset a millisecond early or late, and so would timing from the press rather than the release. It sends pushbutton pulses shorter than the debounce window: a design that reacts to the level would produce a spurious reset. It also runs strobe sequences made only of rising edges, which a design that kicks on any edge would wrongly accept. It changes the period select while the watchdog is counting: a design with an equality compare would miss the limit and never fire. Finally, it injects a power-fail pulse and a power-on pulse in the middle of a stretch. A design that does not restart the interval would release reset too early.

// File: rtl/supv_pkg.sv
package supv_pkg;
  function automatic int cnt_w(input int maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // watchdog period in ms for a select code; 2'b11 behaves like 2'b10
  function automatic int wd_period(input logic [1:0] sel, input int s, input int m, input int l);
    case (sel)
      2'b00:   return s;
      2'b01:   return m;
      default: return l;
    endcase
  endfunction
endpackage

// File: rtl/supv_tick.sv
module supv_tick #(
  parameter int CLK_PER_MS = 125000
) (
  input  logic clk,
  input  logic por_n_i,
  output logic tick_o
);
  localparam int W = supv_pkg::cnt_w(CLK_PER_MS - 1);
  logic [W-1:0] cnt;

  assign tick_o = (cnt == W'(CLK_PER_MS - 1));

  always_ff @(posedge clk or negedge por_n_i) begin
    if (!por_n_i)    cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int            WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             por_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge por_n_i) begin
      if (!por_n_i) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int DEBOUNCE_MS = 20
) (
  input  logic clk,
  input  logic por_n_i,
  input  logic tick_i,
  input  logic pb_n_s_i,
  output logic pressed_o
);
  localparam int W = supv_pkg::cnt_w(DEBOUNCE_MS);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n_i) begin
    if (!por_n_i) begin
      cnt       <= '0;
      pressed_o <= 1'b0;
    end else if (pb_n_s_i) begin
      cnt       <= '0;
      pressed_o <= 1'b0;
    end else if (!pressed_o && tick_i) begin
      if (cnt == W'(DEBOUNCE_MS)) pressed_o <= 1'b1;
      else                        cnt <= cnt + 1'b1;
    end
  end

  // R3: a high sample cancels the press on the next edge
  p_release_cancels_r3: assert property (@(posedge clk) disable iff (!por_n_i)
    pb_n_s_i |=> !pressed_o);
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog #(
  parameter int WD_SHORT_MS = 150,
  parameter int WD_MID_MS   = 600,
  parameter int WD_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       por_n_i,
  input  logic       tick_i,
  input  logic       rst_active_i,
  input  logic       strobe_s_i,
  input  logic [1:0] sel_i,
  output logic       kick_o,
  output logic       bite_o
);
  localparam int W = supv_pkg::cnt_w(supv_pkg::max3(WD_SHORT_MS, WD_MID_MS, WD_LONG_MS));
  logic [W-1:0] cnt, lim;
  logic         st_d;

  assign lim    = W'(supv_pkg::wd_period(sel_i, WD_SHORT_MS, WD_MID_MS, WD_LONG_MS));
  assign kick_o = st_d & ~strobe_s_i;
  assign bite_o = ~rst_active_i & ~kick_o & tick_i & (cnt >= lim);

  always_ff @(posedge clk or negedge por_n_i) begin
    if (!por_n_i) begin
      cnt  <= '0;
      st_d <= 1'b1;
    end else begin
      st_d <= strobe_s_i;
      if (rst_active_i || kick_o) cnt <= '0;
      else if (tick_i) begin
        if (cnt >= lim) cnt <= '0;
        else            cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: count is frozen at zero while reset is active
  p_frozen_in_reset_r6: assert property (@(posedge clk) disable iff (!por_n_i)
    rst_active_i |=> (cnt == '0));
  // R7: a falling strobe edge restarts the count
  p_kick_restarts_r7: assert property (@(posedge clk) disable iff (!por_n_i)
    (kick_o && !rst_active_i) |=> (cnt == '0));
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
  parameter int STRETCH_MS = 250
) (
  input  logic clk,
  input  logic por_n_i,
  input  logic tick_i,
  input  logic cause_i,
  output logic active_o
);
  localparam int W = supv_pkg::cnt_w(STRETCH_MS);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n_i) begin
    if (!por_n_i) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (cause_i) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (active_o && tick_i) begin
      if (cnt == W'(STRETCH_MS)) active_o <= 1'b0;
      else                       cnt <= cnt + 1'b1;
    end
  end

  // R1: any cause asserts reset on the next edge
  p_cause_asserts_r1: assert property (@(posedge clk) disable iff (!por_n_i)
    cause_i |=> active_o);
  // R11: a cause restarts the hold interval
  p_cause_restarts_r11: assert property (@(posedge clk) disable iff (!por_n_i)
    cause_i |=> (cnt == '0));
  // R2: release only on a tick with no cause present
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!por_n_i)
    $fell(active_o) |-> ($past(tick_i) && !$past(cause_i)));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int CLK_PER_MS  = 125000,
  parameter int STRETCH_MS  = 250,
  parameter int DEBOUNCE_MS = 20,
  parameter int WD_SHORT_MS = 150,
  parameter int WD_MID_MS   = 600,
  parameter int WD_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       por_n_i,
  input  logic       pwr_fail_i,
  input  logic       pb_n_i,
  input  logic       strobe_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o,
  output logic       rst_n_o
);
  logic       tick, pressed, kick, bite, cause, active;
  logic [1:0] sync_q;

  supv_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .por_n_i(por_n_i), .tick_o(tick));

  supv_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .por_n_i(por_n_i), .d_i({strobe_i, pb_n_i}), .q_o(sync_q));

  supv_debounce #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_deb (
    .clk(clk), .por_n_i(por_n_i), .tick_i(tick), .pb_n_s_i(sync_q[0]),
    .pressed_o(pressed));

  supv_watchdog #(.WD_SHORT_MS(WD_SHORT_MS), .WD_MID_MS(WD_MID_MS),
                  .WD_LONG_MS(WD_LONG_MS)) u_wd (
    .clk(clk), .por_n_i(por_n_i), .tick_i(tick), .rst_active_i(active),
    .strobe_s_i(sync_q[1]), .sel_i(wd_sel_i), .kick_o(kick), .bite_o(bite));

  assign cause = pwr_fail_i | pressed | bite;

  supv_stretch #(.STRETCH_MS(STRETCH_MS)) u_str (
    .clk(clk), .por_n_i(por_n_i), .tick_i(tick), .cause_i(cause),
    .active_o(active));

  assign rst_o   = active;
  assign rst_n_o = ~active;

  // R6: an expiry only occurs while reset is released
  p_bite_only_released_r6: assert property (@(posedge clk) disable iff (!por_n_i)
    bite |-> !rst_o);
  // R8: an expiry always produces reset on the next edge
  p_bite_resets_r8: assert property (@(posedge clk) disable iff (!por_n_i)
    bite |=> rst_o);
  // R7: a kick never coincides with an expiry
  p_kick_blocks_bite_r7: assert property (@(posedge clk) disable iff (!por_n_i)
    kick |-> !bite);
endmodule

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
  localparam int CPM = 4, STR = 5, DEB = 3, WS = 8, WM = 12, WL = 16;

  logic clk = 0, por_n = 0, pwr_fail = 0, pb_n = 1, strobe = 1;
  logic [1:0] sel = 2'b00;
  logic rst, rst_n;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit kick_en = 0, done = 0;
  string phase = "R10";

  always #4 clk = ~clk;

  rst_supervisor #(.CLK_PER_MS(CPM), .STRETCH_MS(STR), .DEBOUNCE_MS(DEB),
    .WD_SHORT_MS(WS), .WD_MID_MS(WM), .WD_LONG_MS(WL)) dut_i (
    .clk(clk), .por_n_i(por_n), .pwr_fail_i(pwr_fail), .pb_n_i(pb_n),
    .strobe_i(strobe), .wd_sel_i(sel), .rst_o(rst), .rst_n_o(rst_n));

  // behavioural reference: elapsed-time bookkeeping in integers
  int ms_phase, pb_hist[$], st_hist[$], st_last, low_ms, wd_ms, hold_ms;
  bit pressed, in_reset;

  function automatic int period(input logic [1:0] s);
    if (s == 2'b00) return WS;
    if (s == 2'b01) return WM;
    return WL;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ms_phase = 0; pb_hist = '{1, 1}; st_hist = '{1, 1}; st_last = 1;
      low_ms = 0; wd_ms = 0; hold_ms = 0; pressed = 0; in_reset = 1;
    end else begin
      bit edge_ms, fell, expire, why;
      edge_ms = (ms_phase == CPM - 1);
      fell    = (st_last == 1) && (st_hist[1] == 0);
      expire  = !in_reset && !fell && edge_ms && (wd_ms >= period(sel));
      why     = pwr_fail || pressed || expire;
      if (pb_hist[1] == 1) begin low_ms = 0; pressed = 0; end
      else if (!pressed && edge_ms) begin
        if (low_ms == DEB) pressed = 1; else low_ms++;
      end
      if (in_reset || fell) wd_ms = 0;
      else if (edge_ms) wd_ms = (wd_ms >= period(sel)) ? 0 : wd_ms + 1;
      if (why) begin in_reset = 1; hold_ms = 0; end
      else if (in_reset && edge_ms) begin
        if (hold_ms == STR) in_reset = 0; else hold_ms++;
      end
      st_last = st_hist[1];
      void'(pb_hist.pop_back()); pb_hist.push_front(int'(pb_n));
      void'(st_hist.pop_back()); st_hist.push_front(int'(strobe));
      ms_phase = edge_ms ? 0 : ms_phase + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      n_cmp++;
      if (rst !== in_reset) begin
        n_bad++;
        $display("FAIL %s: rst_o=%0b expected %0b at cycle %0d", phase, rst, in_reset, cyc);
      end
      n_cmp++;
      if (rst_n !== ~rst) begin
        n_bad++;
        $display("FAIL R9: rst_n_o=%0b expected %0b at cycle %0d", rst_n, ~rst, cyc);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin : strobe_driver
    forever begin
      wait_cyc(10);
      if (kick_en) strobe = ~strobe;
    end
  end

  initial begin : watchdog_timer
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    phase = "R10"; wait_cyc(3); por_n = 1; wait_cyc(40);
    phase = "R6";  kick_en = 1; wait_cyc(200);
    phase = "R8";  kick_en = 0; wait_cyc(300);
    phase = "R5";  sel = 2'b01; wait_cyc(250);
    sel = 2'b10; wait_cyc(250);
    sel = 2'b11; wait_cyc(200);
    sel = 2'b10; wait_cyc(60); sel = 2'b00; wait_cyc(100);
    phase = "R7";  wait_cyc(40); strobe = 0; wait_cyc(8); strobe = 1; wait_cyc(20);
    strobe = 1; wait_cyc(150);
    phase = "R1";  sel = 2'b10; kick_en = 1; wait_cyc(50);
    pwr_fail = 1; wait_cyc(30); pwr_fail = 0; wait_cyc(60);
    phase = "R3";  pb_n = 0; wait_cyc(5); pb_n = 1; wait_cyc(40);
    pb_n = 0; wait_cyc(14); pb_n = 1; wait_cyc(40);
    phase = "R4";  pb_n = 0; wait_cyc(60); pb_n = 1; wait_cyc(60);
    phase = "R11"; pwr_fail = 1; wait_cyc(4); pwr_fail = 0; wait_cyc(12);
    pwr_fail = 1; wait_cyc(2); pwr_fail = 0; wait_cyc(60);
    phase = "R10"; wait_cyc(7); por_n = 0; wait_cyc(3); por_n = 1; wait_cyc(15);
    pwr_fail = 1; wait_cyc(1); pwr_fail = 0; wait_cyc(50);
    phase = "R2";  kick_en = 0; sel = 2'b00; wait_cyc(200);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule